// File: doc/BRIEF.md
# Control-Region REG Index Generator

This block walks the downlink control region of one subframe and lists every resource-element group (REG) in canonical order. A REG is a set of four data subcarriers in one OFDM symbol. For each REG the block reports four things:

- the symbol number;
- the base subcarrier of the group;
- the four data subcarrier indices;
- the flat grid address `k0 + l*NPRB*12`.

A single start pulse latches the cell configuration: the bandwidth in resource blocks, the antenna port count, the cyclic-prefix type and the cell identity. The block then streams the REGs on a valid/ready interface, one REG per cycle while the consumer accepts them. When the last REG has been taken, the block pulses done and presents the number of REGs it produced.

Downstream logic, such as a channel allocator or a REG table writer, consumes the stream. This block does not store the table and does not assign REGs to channels.

A configuration that cannot be mapped sets an error flag and produces no stream. Such a configuration is a port count outside {1, 2, 4}, or a bandwidth of zero or above the supported maximum.

Top module: `reg_index_gen`

## Requirements
- R1: The number of REGs per resource block in each symbol is as follows. Symbol 0 has 2. Symbol 1 has 3 when the port count is 1 or 2, and 2 when it is 4. Symbol 2 has 3. Symbol 3 has 2 when `ext_cp_i` is 1 (extended prefix) and 3 otherwise.
- R2: The control region spans 4 symbols when `nprb_i` is below 10, and 3 symbols otherwise.
- R3: In a symbol with 3 REGs per block, REG j of block p has `k0 = 12p + 4j`. Its data subcarriers are k0, k0+1, k0+2 and k0+3.
- R4: In a symbol with 2 REGs per block, REG j of block p has `k0 = 12p + 6j`. Its data subcarriers are the four offsets 0..5 from k0 that are neither vo nor vo+3 (vo = cell_id mod 3), in ascending order. `k_o` carries data subcarrier i in bits `[i*SC_W +: SC_W]`.
- R5: Blocks are visited in ascending order. Within a block there are three sub-positions. At each sub-position the block visits symbols 0 up to the last control symbol, in that order. A symbol with 2 REGs per block emits nothing at the middle sub-position. At the first sub-position it emits REG 0, and at the last sub-position it emits REG 1.
- R6: `addr_o` equals `k0_o + sym_o * nprb * 12`.
- R7: `done_o` pulses for one cycle, in the cycle after the handshake on the last REG. While `done_o` is high, `total_o` equals NPRB times the sum of REGs per block over the control symbols, and `valid_o` is low.
- R8: While `ready_i` stays high, one REG is transferred every cycle with no gap. While `valid_o` is high and `ready_i` is low, the outputs hold their values.
- R9: A start pulse with a port count other than 1, 2 or 4, or with `nprb_i` of 0 or above `MAX_PRB`, sets `err_o`. No REG and no done pulse follow. The next accepted start clears `err_o`.
- R10: A start pulse that arrives while a stream is in progress is ignored, and the stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch the configuration and begin a stream |
| nprb_i | input | PRB_W | Bandwidth in resource blocks |
| nports_i | input | 3 | Antenna port count |
| ext_cp_i | input | 1 | 1 = extended cyclic prefix |
| cell_id_i | input | CELL_W | Cell identity |
| ready_i | input | 1 | Consumer accepts the current REG |
| valid_o | output | 1 | A REG is presented |
| sym_o | output | 2 | Symbol of the REG |
| k0_o | output | SC_W | Base subcarrier of the REG |
| k_o | output | 4*SC_W | Four data subcarriers, index 0 in the low bits |
| addr_o | output | AW | Flat grid address of k0 |
| done_o | output | 1 | One-cycle completion pulse |
| total_o | output | CNT_W | Count of REGs produced |
| err_o | output | 1 | Last start request was rejected |

## Verification
Two events can fall on the same clock edge: the handshake on the final REG, and the end-of-stream report (the done pulse together with the REG count). The consumer may also stall on that final REG. The bench withholds `ready_i` at random, including on the last REG, and checks the following:

- `done_o` rises exactly once, one sample after the final accepted REG.
- `total_o` at that moment equals the count that the bench model derives from the configuration.

A second collision is a start request that lands in the middle of a stalled stream. The bench provokes it and checks that the held REG and all later REGs still match the original configuration.

// File: rtl/reggen_pkg.sv
`timescale 1ns/1ps
package reggen_pkg;

  localparam int unsigned SC_PER_PRB = 12;
  localparam int unsigned RE_PER_REG = 4;

  // position inside one resource block walk
  typedef struct packed {
    logic [1:0] sub;
    logic [1:0] sym;
    logic       wrap;
  } pos_t;

  // groups per resource block in a given control symbol
  function automatic logic [1:0] regs_in_symbol(input logic [1:0] sym,
                                                input logic       four_port,
                                                input logic       ext_cp);
    logic [1:0] n;
    case (sym)
      2'd0:    n = 2'd2;
      2'd1:    n = four_port ? 2'd2 : 2'd3;
      2'd2:    n = 2'd3;
      default: n = ext_cp ? 2'd2 : 2'd3;
    endcase
    return n;
  endfunction

  // offset of data element idx inside a six-wide span, jumping the two pilots
  function automatic logic [2:0] pilot_skip_offset(input logic [1:0] idx,
                                                   input logic [1:0] vo);
    logic [2:0] o;
    o = {1'b0, idx} + ((idx >= vo) ? 3'd1 : 3'd0);
    if (o >= ({1'b0, vo} + 3'd3)) o = o + 3'd1;
    return o;
  endfunction

  // a symbol with two groups per block has nothing at the middle sub-position
  function automatic logic emits_at(input logic [1:0] sub, input logic [1:0] nreg);
    return !((nreg == 2'd2) && (sub == 2'd1));
  endfunction

endpackage

// File: rtl/reggen_cfg.sv
`timescale 1ns/1ps
module reggen_cfg
  import reggen_pkg::*;
#(
  parameter int MAX_PRB = 110,
  parameter int CELL_W  = 9,
  localparam int PRB_W  = $clog2(MAX_PRB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [PRB_W-1:0] nprb_i,
  input  logic [2:0]       nports_i,
  input  logic             ext_cp_i,
  input  logic [CELL_W-1:0] cell_id_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic [PRB_W-1:0] nprb_o,
  output logic [2:0]       max_sym_o,
  output logic [1:0]       vo_o,
  output logic [3:0][1:0]  nreg_o
);

  logic ports_ok, prb_ok, req;
  logic four_q, ext_q;
  logic [1:0] vo_d;

  assign ports_ok = (nports_i == 3'd1) || (nports_i == 3'd2) || (nports_i == 3'd4);
  assign prb_ok   = (nprb_i != '0) && (nprb_i <= PRB_W'(MAX_PRB));
  assign req      = start_i && !busy_i;
  assign accept_o = req && ports_ok && prb_ok;
  assign reject_o = req && !(ports_ok && prb_ok);
  assign vo_d     = 2'(cell_id_i % CELL_W'(3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nprb_o <= '0;
      four_q <= 1'b0;
      ext_q  <= 1'b0;
      vo_o   <= '0;
    end else if (accept_o) begin
      nprb_o <= nprb_i;
      four_q <= (nports_i == 3'd4);
      ext_q  <= ext_cp_i;
      vo_o   <= vo_d;
    end
  end

  assign max_sym_o = (nprb_o < PRB_W'(10)) ? 3'd4 : 3'd3;

  for (genvar s = 0; s < 4; s++) begin : g_sym
    assign nreg_o[s] = regs_in_symbol(2'(s), four_q, ext_q);
  end

endmodule

// File: rtl/reggen_walker.sv
`timescale 1ns/1ps
module reggen_walker
  import reggen_pkg::*;
#(
  parameter int PRB_W = 7,
  parameter int LOOK  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [PRB_W-1:0] nprb_i,
  input  logic [2:0]       max_sym_i,
  input  logic [3:0][1:0]  nreg_i,
  output logic             busy_o,
  output logic [PRB_W-1:0] prb_o,
  output logic [1:0]       sub_o,
  output logic [1:0]       sym_o,
  output logic             last_o
);

  pos_t cand [LOOK+1];
  logic emit [1:LOOK];
  pos_t nxt;

  function automatic pos_t step(input pos_t p, input logic [2:0] ms);
    pos_t n;
    n      = p;
    n.wrap = 1'b0;
    if (({1'b0, p.sym} + 3'd1) == ms) begin
      n.sym = 2'd0;
      if (p.sub == 2'd2) begin
        n.sub  = 2'd0;
        n.wrap = 1'b1;
      end else begin
        n.sub = p.sub + 2'd1;
      end
    end else begin
      n.sym = p.sym + 2'd1;
    end
    return n;
  endfunction

  assign cand[0] = '{sub: sub_o, sym: sym_o, wrap: 1'b0};

  for (genvar i = 1; i <= LOOK; i++) begin : g_look
    pos_t s;
    assign s       = step(cand[i-1], max_sym_i);
    assign cand[i] = '{sub: s.sub, sym: s.sym, wrap: s.wrap | cand[i-1].wrap};
    assign emit[i] = emits_at(s.sub, nreg_i[s.sym]);
  end

  always_comb begin
    nxt = cand[LOOK];
    for (int i = LOOK; i >= 1; i--) begin
      if (emit[i]) nxt = cand[i];
    end
  end

  assign last_o = busy_o && (prb_o == nprb_i - PRB_W'(1)) && (sub_o == 2'd2) &&
                  (({1'b0, sym_o} + 3'd1) == max_sym_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      prb_o  <= '0;
      sub_o  <= '0;
      sym_o  <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      prb_o  <= '0;
      sub_o  <= '0;
      sym_o  <= '0;
    end else if (adv_i && busy_o) begin
      if (last_o) begin
        busy_o <= 1'b0;
      end else begin
        prb_o <= prb_o + (nxt.wrap ? PRB_W'(1) : PRB_W'(0));
        sub_o <= nxt.sub;
        sym_o <= nxt.sym;
      end
    end
  end

endmodule

// File: rtl/reggen_layout.sv
`timescale 1ns/1ps
module reggen_layout
  import reggen_pkg::*;
#(
  parameter int PRB_W = 7,
  parameter int SC_W  = 11,
  parameter int AW    = 13
) (
  input  logic [PRB_W-1:0]         prb_i,
  input  logic [1:0]               sub_i,
  input  logic [1:0]               sym_i,
  input  logic [1:0]               nreg_i,
  input  logic [1:0]               vo_i,
  input  logic [PRB_W-1:0]         nprb_i,
  output logic [SC_W-1:0]          k0_o,
  output logic [3:0][SC_W-1:0]     k_o,
  output logic [AW-1:0]            addr_o
);

  logic [SC_W-1:0] base;
  logic            dense;
  logic [AW-1:0]   row;

  assign base  = SC_W'(prb_i) * SC_W'(SC_PER_PRB);
  assign dense = (nreg_i == 2'd3);
  assign k0_o  = dense ? base + SC_W'({sub_i, 2'b00})
                       : base + (sub_i[1] ? SC_W'(6) : SC_W'(0));

  for (genvar i = 0; i < RE_PER_REG; i++) begin : g_re
    assign k_o[i] = k0_o + (dense ? SC_W'(i) : SC_W'(pilot_skip_offset(2'(i), vo_i)));
  end

  assign row    = AW'(sym_i) * AW'(nprb_i) * AW'(SC_PER_PRB);
  assign addr_o = AW'(k0_o) + row;

endmodule

// File: rtl/reg_index_gen.sv
`timescale 1ns/1ps
module reg_index_gen
  import reggen_pkg::*;
#(
  parameter int MAX_PRB = 110,
  parameter int CELL_W  = 9,
  localparam int PRB_W  = $clog2(MAX_PRB + 1),
  localparam int SC_W   = $clog2(MAX_PRB * SC_PER_PRB),
  localparam int AW     = $clog2(MAX_PRB * SC_PER_PRB * 4),
  localparam int CNT_W  = $clog2(MAX_PRB * 11 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PRB_W-1:0]  nprb_i,
  input  logic [2:0]        nports_i,
  input  logic              ext_cp_i,
  input  logic [CELL_W-1:0] cell_id_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [1:0]        sym_o,
  output logic [SC_W-1:0]   k0_o,
  output logic [4*SC_W-1:0] k_o,
  output logic [AW-1:0]     addr_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  total_o,
  output logic              err_o
);

  // named internal events, observed by the bound checker
  logic             ev_accept, ev_reject, ev_handshake, ev_final;
  logic [1:0]       ev_sub;
  logic [3:0][1:0]  ev_nreg;

  logic             busy, last;
  logic [PRB_W-1:0] nprb_q, prb;
  logic [2:0]       max_sym;
  logic [1:0]       vo;
  logic [3:0][SC_W-1:0] k_arr;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, err_q;

  reggen_cfg #(.MAX_PRB(MAX_PRB), .CELL_W(CELL_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy),
    .nprb_i(nprb_i), .nports_i(nports_i), .ext_cp_i(ext_cp_i), .cell_id_i(cell_id_i),
    .accept_o(ev_accept), .reject_o(ev_reject), .nprb_o(nprb_q),
    .max_sym_o(max_sym), .vo_o(vo), .nreg_o(ev_nreg)
  );

  reggen_walker #(.PRB_W(PRB_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .load_i(ev_accept), .adv_i(ev_handshake),
    .nprb_i(nprb_q), .max_sym_i(max_sym), .nreg_i(ev_nreg),
    .busy_o(busy), .prb_o(prb), .sub_o(ev_sub), .sym_o(sym_o), .last_o(last)
  );

  reggen_layout #(.PRB_W(PRB_W), .SC_W(SC_W), .AW(AW)) lay_i (
    .prb_i(prb), .sub_i(ev_sub), .sym_i(sym_o), .nreg_i(ev_nreg[sym_o]),
    .vo_i(vo), .nprb_i(nprb_q), .k0_o(k0_o), .k_o(k_arr), .addr_o(addr_o)
  );

  assign valid_o      = busy;
  assign k_o          = k_arr;
  assign ev_handshake = busy && ready_i;
  assign ev_final     = ev_handshake && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= ev_final;
      if (ev_accept)         cnt_q <= '0;
      else if (ev_handshake) cnt_q <= cnt_q + CNT_W'(1);
      if (ev_accept)         err_q <= 1'b0;
      else if (ev_reject)    err_q <= 1'b1;
    end
  end

  assign done_o  = done_q;
  assign total_o = cnt_q;
  assign err_o   = err_q;

endmodule

// File: rtl/reg_index_gen_chk.sv
`timescale 1ns/1ps
module reg_index_gen_chk
  import reggen_pkg::*;
#(
  parameter int MAX_PRB = 110,
  parameter int PRB_W   = 7,
  parameter int SC_W    = 11,
  parameter int AW      = 13,
  parameter int CNT_W   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ready_i,
  input logic [PRB_W-1:0]  nprb_i,
  input logic [2:0]        nports_i,
  input logic              ext_cp_i,
  input logic              valid_o,
  input logic              done_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  total_o,
  input logic [1:0]        sym_o,
  input logic [SC_W-1:0]   k0_o,
  input logic [4*SC_W-1:0] k_o,
  input logic [AW-1:0]     addr_o,
  input logic              ev_accept,
  input logic [1:0]        ev_sub,
  input logic [3:0][1:0]   ev_nreg
);

  logic [CNT_W-1:0] exp_total;
  logic [PRB_W-1:0] nprb_l;
  int unsigned      ka [4];

  function automatic logic [CNT_W-1:0] total_of(input logic [PRB_W-1:0] np,
                                                input logic four, input logic ext);
    int acc;
    acc = 0;
    for (int s = 0; s < 4; s++) begin
      if (s < 3 || np < PRB_W'(10)) acc += int'(regs_in_symbol(2'(s), four, ext));
    end
    return CNT_W'(acc * int'(np));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_total <= '0;
      nprb_l    <= '0;
    end else if (ev_accept) begin
      exp_total <= total_of(nprb_i, nports_i == 3'd4, ext_cp_i);
      nprb_l    <= nprb_i;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) ka[i] = int'(k_o[i*SC_W +: SC_W]);
  end

  p_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> total_o == exp_total);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(addr_o) && $stable(k0_o) && $stable(sym_o));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && start_i) |=> valid_o && $stable(k_o));
  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o && !done_o);
  p_k_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ka[0] >= int'(k0_o) && ka[0] < ka[1] && ka[1] < ka[2] && ka[2] < ka[3] &&
                ka[3] - int'(k0_o) <= 5);
  p_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> int'(addr_o) >= int'(k0_o) &&
                ((int'(addr_o) - int'(k0_o)) % (int'(nprb_l) * 12)) == 0);
  p_emit_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !(ev_nreg[sym_o] == 2'd2 && ev_sub == 2'd1));

endmodule

bind reg_index_gen reg_index_gen_chk #(
  .MAX_PRB(MAX_PRB), .PRB_W(PRB_W), .SC_W(SC_W), .AW(AW), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
  .nprb_i(nprb_i), .nports_i(nports_i), .ext_cp_i(ext_cp_i),
  .valid_o(valid_o), .done_o(done_o), .err_o(err_o), .total_o(total_o),
  .sym_o(sym_o), .k0_o(k0_o), .k_o(k_o), .addr_o(addr_o),
  .ev_accept(ev_accept), .ev_sub(ev_sub), .ev_nreg(ev_nreg)
);

// File: tb/reg_index_gen_tb_top.sv
`timescale 1ns/1ps
module reg_index_gen_tb_top;

  localparam int MAX_PRB = 110;
  localparam int CELL_W  = 9;
  localparam int PRB_W   = $clog2(MAX_PRB + 1);
  localparam int SC_W    = $clog2(MAX_PRB * 12);
  localparam int AW      = $clog2(MAX_PRB * 48);
  localparam int CNT_W   = $clog2(MAX_PRB * 11 + 1);
  localparam int MAXN    = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, ext_cp_i = 1'b0, ready_i = 1'b0;
  logic [PRB_W-1:0]  nprb_i = '0;
  logic [2:0]        nports_i = '0;
  logic [CELL_W-1:0] cell_id_i = '0;
  logic              valid_o, done_o, err_o;
  logic [1:0]        sym_o;
  logic [SC_W-1:0]   k0_o;
  logic [4*SC_W-1:0] k_o;
  logic [AW-1:0]     addr_o;
  logic [CNT_W-1:0]  total_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  int e_l [MAXN], e_k0 [MAXN], e_a [MAXN], e_n [MAXN];
  int e_k [MAXN][4];
  int n_exp;

  always #2 clk = ~clk;

  reg_index_gen #(.MAX_PRB(MAX_PRB), .CELL_W(CELL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nprb_i(nprb_i), .nports_i(nports_i),
    .ext_cp_i(ext_cp_i), .cell_id_i(cell_id_i), .ready_i(ready_i), .valid_o(valid_o),
    .sym_o(sym_o), .k0_o(k0_o), .k_o(k_o), .addr_o(addr_o), .done_o(done_o),
    .total_o(total_o), .err_o(err_o)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int groups(int l, int ports, bit ext);
    if (l == 0) return 2;
    if (l == 1) return (ports == 4) ? 2 : 3;
    if (l == 2) return 3;
    return ext ? 2 : 3;
  endfunction

  task automatic build(int nprb, int ports, bit ext, int cid);
    int ms, vo, k0, m;
    ms = (nprb < 10) ? 4 : 3;
    vo = cid % 3;
    n_exp = 0;
    for (int p = 0; p < nprb; p++)
      for (int pos = 0; pos < 3; pos++)
        for (int l = 0; l < ms; l++) begin
          int g;
          g = groups(l, ports, ext);
          if (g == 3) begin
            k0 = p * 12 + 4 * pos;
            for (int i = 0; i < 4; i++) e_k[n_exp][i] = k0 + i;
          end else if (pos != 1) begin
            k0 = p * 12 + ((pos == 2) ? 6 : 0);
            m = 0;
            for (int off = 0; off < 6; off++)
              if (off != vo && off != vo + 3) begin
                e_k[n_exp][m] = k0 + off;
                m++;
              end
          end else continue;
          e_l[n_exp]  = l;
          e_k0[n_exp] = k0;
          e_n[n_exp]  = g;
          e_a[n_exp]  = k0 + l * nprb * 12;
          n_exp++;
        end
  endtask

  task automatic run_case(int nprb, int ports, bit ext, int cid, int pct, bit poke);
    int idx, cyc;
    bit seen_done, prev_stall;
    int prev_addr;
    idx = 0; cyc = 0; seen_done = 0; prev_stall = 0; prev_addr = 0;
    build(nprb, ports, ext, cid);
    @(negedge clk);
    nprb_i = PRB_W'(nprb); nports_i = 3'(ports); ext_cp_i = ext;
    cell_id_i = CELL_W'(cid); start_i = 1'b1; ready_i = 1'b0;
    while (!seen_done && cyc < 4000) begin
      @(negedge clk);
      ready_i = (($urandom % 100) < pct);
      if (poke && cyc == 7) begin
        start_i = 1'b1; nprb_i = PRB_W'(3); nports_i = 3'd1; cell_id_i = CELL_W'(7);
      end else start_i = 1'b0;
      #1;
      if (cyc == 0) check(err_o == 1'b0, "R9", "err cleared by good start", int'(err_o), 0);
      if (prev_stall) begin
        check(valid_o && int'(addr_o) == prev_addr, poke ? "R10" : "R8",
              "held REG addr", int'(addr_o), prev_addr);
      end
      if (done_o) begin
        seen_done = 1;
        check(idx == n_exp, "R7", "done after last REG", idx, n_exp);
        check(int'(total_o) == n_exp, "R1 R2 R7", "total", int'(total_o), n_exp);
        check(!valid_o, "R7", "valid low at done", int'(valid_o), 0);
        if (pct >= 100) check(cyc == n_exp, "R8", "gapless cycles", cyc, n_exp);
      end else if (valid_o && ready_i) begin
        if (idx >= n_exp) begin
          check(0, "R5", "extra REG", idx, n_exp);
        end else begin
          check(int'(sym_o) == e_l[idx], "R5", "symbol order", int'(sym_o), e_l[idx]);
          check(int'(k0_o) == e_k0[idx], "R5", "k0", int'(k0_o), e_k0[idx]);
          for (int i = 0; i < 4; i++)
            check(int'(k_o[i*SC_W +: SC_W]) == e_k[idx][i], (e_n[idx] == 3) ? "R3" : "R4",
                  "data subcarrier", int'(k_o[i*SC_W +: SC_W]), e_k[idx][i]);
          check(int'(addr_o) == e_a[idx], "R6", "addr", int'(addr_o), e_a[idx]);
        end
        idx++;
      end
      prev_stall = valid_o && !ready_i;
      prev_addr  = int'(addr_o);
      cyc++;
    end
    check(seen_done, "R7", "done seen", int'(seen_done), 1);
    @(negedge clk); start_i = 1'b0; #1;
    check(!done_o, "R7", "done single pulse", int'(done_o), 0);
  endtask

  task automatic bad_start(int nprb, int ports);
    @(negedge clk);
    nprb_i = PRB_W'(nprb); nports_i = 3'(ports); start_i = 1'b1; ready_i = 1'b1;
    @(negedge clk); start_i = 1'b0; #1;
    check(err_o == 1'b1, "R9", "err raised", int'(err_o), 1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); #1;
      check(!valid_o && !done_o, "R9", "silent after reject", int'(valid_o), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check(!valid_o && !done_o, "R7", "reset idle", int'(valid_o), 0);
    check(total_o == '0, "R7", "reset count", int'(total_o), 0);
    check(!err_o, "R9", "reset err", int'(err_o), 0);

    run_case(6, 1, 0, 0, 100, 0);    // four symbols, vo 0
    run_case(6, 4, 1, 5, 60, 0);     // sparse symbols 1 and 3, vo 2
    run_case(9, 2, 1, 301, 100, 0);  // last bandwidth with four symbols
    run_case(10, 2, 0, 1, 100, 0);   // first bandwidth with three symbols
    run_case(110, 4, 0, 301, 100, 0);
    run_case(1, 1, 0, 2, 30, 0);
    run_case(50, 2, 0, 4, 20, 1);    // start request while stalled
    bad_start(20, 3);
    bad_start(20, 0);
    bad_start(0, 2);
    bad_start(111, 1);
    run_case(12, 1, 1, 8, 100, 0);   // clears the error
    for (int r = 0; r < 12; r++) begin
      int np, pp;
      np = 1 + int'($urandom % 110);
      pp = (($urandom % 3) == 0) ? 1 : ((($urandom % 2) == 0) ? 2 : 4);
      run_case(np, pp, bit'($urandom % 2), int'($urandom % 504), 40 + int'($urandom % 61), 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule